// File: doc/BRIEF.md
# Dual-Processor Mailbox Doorbell Controller

This block lets two processors, numbered 0 and 1, ring doorbells at each other over up to sixteen one-way channels. Each processor has its own register bank with four registers: control, mask, command and status. Processor 0's bank is at 0x000 and processor 1's bank is 0x10 bytes higher. A processor writes its command register to mark one of its channels as occupied toward the peer. The peer answers by writing its own command register to free that channel again. The per-processor status register shows which of that processor's outgoing channels are occupied.

Each processor drives two level interrupts. The receive line tells it that the peer has occupied a channel. The transmit line tells it that one of its own outgoing channels is free. Each line has its own enable bit and its own per-channel masks. Any processor can read any register, including the peer's status, which shows what is pending toward it. A processor can write only its own bank. A read-only configuration word gives the channel count, and a version word gives the revision. Each processor has its own single-cycle register bus. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `dual_mbox_doorbell`

## Requirements
- R1: After reset, all occupied flags read 0 and both control registers read 0. Every implemented mask bit reads 1, so each mask register reads {CHM,CHM}, where CHM has the low NCH bits set. All four interrupts are low.
- R2: Processor p writes its command register at 0x008 (p=0) or 0x018 (p=1). A 1 in bit 16+n sets that processor's occupied flag for channel n. Processor 0's flags read in bits n of its status at 0x00C, and processor 1's flags read at 0x01C.
- R3: A 1 in command bit n of processor p clears the peer's occupied flag n. Bits written as 0 change nothing, and the command register reads as 0.
- R4: Processor p may set channel n in the same cycle as the peer clears it. The flag is then 1 after that edge, and a clear of a different channel in that cycle still takes effect.
- R5: Control bit 0 is the receive enable. irq_rxP is high when that bit is set and some channel n is occupied by the peer with receive mask bit n (bits 15:0 at 0x004/0x014) at 0.
- R6: Control bit 16 is the transmit enable. irq_txP is high when that bit is set and some implemented channel n of this processor is free with transmit mask bit 16+n at 0.
- R7: Either bus reads every bank register. Writes to the peer's bank are ignored.
- R8: Offset 0x3F0 reads NCH in bits 7:0. Offset 0x3F4 reads VER_MINOR in bits 3:0 and VER_MAJOR in bits 7:4. All other bits read 0.
- R9: Flag and mask bits of channels at or above NCH read 0, and writes to them have no effect.
- R10: Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p0_sel | input | 1 | Processor 0 bus access strobe |
| p0_we | input | 1 | Processor 0 write (1) or read (0) |
| p0_addr | input | 10 | Processor 0 byte address |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data, combinational |
| p1_sel | input | 1 | Processor 1 bus access strobe |
| p1_we | input | 1 | Processor 1 write (1) or read (0) |
| p1_addr | input | 10 | Processor 1 byte address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data, combinational |
| irq_rx0 | output | 1 | Processor 0 receive interrupt |
| irq_tx0 | output | 1 | Processor 0 transmit interrupt |
| irq_rx1 | output | 1 | Processor 1 receive interrupt |
| irq_tx1 | output | 1 | Processor 1 transmit interrupt |

## Verification
The assertions check on every cycle that:
- a set command leaves its flags at 1, even against a clear in the same cycle;
- a clear from the peer alone drops the flag;
- flags never move without a command write;
- status reads never show unimplemented channels.

Some behaviours only the bench scenarios can show:
- the interrupt levels under the different mask and enable patterns;
- writes to the peer bank being ignored;
- the configuration and version words and the reset values.

// File: rtl/dual_mbox_doorbell.sv
module dual_mbox_doorbell #(
  parameter int NCH       = 16,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        p0_sel,
  input  logic        p0_we,
  input  logic [9:0]  p0_addr,
  input  logic [31:0] p0_wdata,
  output logic [31:0] p0_rdata,
  input  logic        p1_sel,
  input  logic        p1_we,
  input  logic [9:0]  p1_addr,
  input  logic [31:0] p1_wdata,
  output logic [31:0] p1_rdata,
  output logic        irq_rx0,
  output logic        irq_tx0,
  output logic        irq_rx1,
  output logic        irq_tx1
);
  localparam logic [15:0] CHM     = 16'((33'h1 << NCH) - 33'h1);
  localparam logic [31:0] MSK_RST = {CHM, CHM};
  localparam logic [31:0] CFG_W   = 32'(NCH);
  localparam logic [31:0] VER_W   = {24'h0, 4'(VER_MAJOR), 4'(VER_MINOR)};

  logic [7:0]  wa0, wa1;
  logic        wr0, wr1, cmd0, cmd1, ctl0, ctl1, mk0, mk1;
  logic [15:0] set0, set1, ack0, ack1;
  logic [15:0] occ0, occ1;
  logic [31:0] msk0, msk1;
  logic        rxen0, txen0, rxen1, txen1;
  logic [31:0] ctlr0, ctlr1;

  assign wa0  = p0_addr[9:2];
  assign wa1  = p1_addr[9:2];
  assign wr0  = p0_sel & p0_we;
  assign wr1  = p1_sel & p1_we;
  assign ctl0 = wr0 && wa0 == 8'd0;
  assign mk0  = wr0 && wa0 == 8'd1;
  assign cmd0 = wr0 && wa0 == 8'd2;
  assign ctl1 = wr1 && wa1 == 8'd4;
  assign mk1  = wr1 && wa1 == 8'd5;
  assign cmd1 = wr1 && wa1 == 8'd6;

  assign set0 = cmd0 ? (p0_wdata[31:16] & CHM) : 16'h0;
  assign ack0 = cmd0 ? (p0_wdata[15:0]  & CHM) : 16'h0;
  assign set1 = cmd1 ? (p1_wdata[31:16] & CHM) : 16'h0;
  assign ack1 = cmd1 ? (p1_wdata[15:0]  & CHM) : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ0  <= '0;
      occ1  <= '0;
      msk0  <= MSK_RST;
      msk1  <= MSK_RST;
      rxen0 <= 1'b0;
      txen0 <= 1'b0;
      rxen1 <= 1'b0;
      txen1 <= 1'b0;
    end else begin
      occ0 <= set0 | (occ0 & ~ack1);
      occ1 <= set1 | (occ1 & ~ack0);
      if (mk0) msk0 <= p0_wdata & MSK_RST;
      if (mk1) msk1 <= p1_wdata & MSK_RST;
      if (ctl0) begin
        rxen0 <= p0_wdata[0];
        txen0 <= p0_wdata[16];
      end
      if (ctl1) begin
        rxen1 <= p1_wdata[0];
        txen1 <= p1_wdata[16];
      end
    end
  end

  assign ctlr0 = {15'h0, txen0, 15'h0, rxen0};
  assign ctlr1 = {15'h0, txen1, 15'h0, rxen1};

  function automatic logic [31:0] rd_mux(input logic [7:0] wa);
    case (wa)
      8'd0:    rd_mux = ctlr0;
      8'd1:    rd_mux = msk0;
      8'd3:    rd_mux = {16'h0, occ0};
      8'd4:    rd_mux = ctlr1;
      8'd5:    rd_mux = msk1;
      8'd7:    rd_mux = {16'h0, occ1};
      8'hFC:   rd_mux = CFG_W;
      8'hFD:   rd_mux = VER_W;
      default: rd_mux = 32'h0;
    endcase
  endfunction

  assign p0_rdata = p0_sel ? rd_mux(wa0) : 32'h0;
  assign p1_rdata = p1_sel ? rd_mux(wa1) : 32'h0;

  assign irq_rx0 = rxen0 & |(occ1 & ~msk0[15:0]);
  assign irq_rx1 = rxen1 & |(occ0 & ~msk1[15:0]);
  assign irq_tx0 = txen0 & |(~occ0 & CHM & ~msk0[31:16]);
  assign irq_tx1 = txen1 & |(~occ1 & CHM & ~msk1[31:16]);

  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cmd0 |=> ((occ0 & $past(set0)) == $past(set0)));
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd1 && (ack1 & ~set0) != 16'h0) |=> ((occ0 & $past(ack1 & ~set0)) == 16'h0));
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0 && cmd1) |=> ((occ0 & $past(set0 & ack1)) == $past(set0 & ack1)));
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd0 || cmd1) |=> ($stable(occ0) && $stable(occ1)));
  a_r9_status_width: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_sel && !p1_we && wa1 == 8'd3) |-> ((p1_rdata & ~{16'h0, CHM}) == 32'h0));
endmodule

// File: tb/dual_mbox_doorbell_tb.sv
module dual_mbox_doorbell_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        p0_sel = 0, p0_we = 0, p1_sel = 0, p1_we = 0;
  logic [9:0]  p0_addr = 0, p1_addr = 0;
  logic [31:0] p0_wdata = 0, p1_wdata = 0;
  logic [31:0] p0_rdata, p1_rdata;
  logic        irq_rx0, irq_tx0, irq_rx1, irq_tx1;
  int          nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dual_mbox_doorbell #(.NCH(12), .VER_MAJOR(2), .VER_MINOR(3)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .p0_sel(p0_sel), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_sel(p1_sel), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .irq_rx0(irq_rx0), .irq_tx0(irq_tx0), .irq_rx1(irq_rx1), .irq_tx1(irq_tx1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    p0_sel = 0; p0_we = 0; p1_sel = 0; p1_we = 0;
  endtask

  task automatic wr(input int p, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin p0_sel = 1; p0_we = 1; p0_addr = a; p0_wdata = d; end
    else        begin p1_sel = 1; p1_we = 1; p1_addr = a; p1_wdata = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    p0_sel = 1; p0_we = 1; p0_addr = 10'h008; p0_wdata = d0;
    p1_sel = 1; p1_we = 1; p1_addr = 10'h018; p1_wdata = d1;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input int p, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin p0_sel = 1; p0_we = 0; p0_addr = a; end
    else        begin p1_sel = 1; p1_we = 0; p1_addr = a; end
    #1;
    d = (p == 0) ? p0_rdata : p1_rdata;
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 10'h004, v); chk("R1 mask0", v, 32'h0FFF0FFF);
    rd(1, 10'h014, v); chk("R1 mask1", v, 32'h0FFF0FFF);
    rd(0, 10'h00C, v); chk("R1 status0", v, 0);
    rd(1, 10'h01C, v); chk("R1 status1", v, 0);
    rd(0, 10'h000, v); chk("R1 ctrl0", v, 0);
    rd(1, 10'h010, v); chk("R1 ctrl1", v, 0);
    chk("R1 irqs", {28'h0, irq_rx0, irq_tx0, irq_rx1, irq_tx1}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    rd(0, 10'h3F0, v); chk("R8 cfg", v, 32'd12);
    rd(1, 10'h3F4, v); chk("R8 version", v, 32'h23);
    rd(0, 10'h100, v); chk("R10 unmapped", v, 0);
    rd(1, 10'h3F8, v); chk("R10 unmapped hi", v, 0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(0, 10'h008, 32'h0005_0000);
    rd(1, 10'h00C, v); chk("R2 R7 peer reads status0", v, 32'h5);
    rd(0, 10'h008, v); chk("R3 cmd reads zero", v, 0);
    rd(1, 10'h01C, v); chk("R2 status1 untouched", v, 0);
  endtask

  task automatic t_rx_irq();
    logic [31:0] v;
    wr(1, 10'h014, 32'hFFFF_FFFE);
    rd(1, 10'h014, v); chk("R9 mask write trimmed", v, 32'h0FFF0FFE);
    chk("R5 rx1 disabled", irq_rx1, 0);
    wr(1, 10'h010, 32'h0000_0001);
    chk("R5 rx1 enabled", irq_rx1, 1);
    chk("R5 rx0 quiet", irq_rx0, 0);
    wr(1, 10'h010, 32'h0);
    chk("R5 rx1 off again", irq_rx1, 0);
    wr(1, 10'h010, 32'h0000_0001);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    wr(1, 10'h018, 32'h0000_0001);
    rd(0, 10'h00C, v); chk("R3 ack clears ch0", v, 32'h4);
    chk("R5 rx1 drops", irq_rx1, 0);
    wr(1, 10'h018, 32'h0);
    rd(0, 10'h00C, v); chk("R3 zero write no effect", v, 32'h4);
  endtask

  task automatic t_tx_irq();
    wr(0, 10'h004, 32'hFFFB_FFFF);
    wr(0, 10'h000, 32'h0001_0000);
    chk("R6 tx0 busy ch2", irq_tx0, 0);
    wr(1, 10'h018, 32'h0000_0004);
    chk("R6 tx0 free ch2", irq_tx0, 1);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(0, 10'h008, 32'h0002_0000);
    rd(0, 10'h00C, v); chk("R2 ch1 set", v, 32'h2);
    wr_both(32'h0002_0000, 32'h0000_0002);
    rd(0, 10'h00C, v); chk("R4 set wins", v, 32'h2);
    wr_both(32'h0008_0000, 32'h0000_0002);
    rd(0, 10'h00C, v); chk("R4 other clear lands", v, 32'h8);
  endtask

  task automatic t_peer_write();
    logic [31:0] v;
    wr(0, 10'h014, 32'h0);
    rd(0, 10'h014, v); chk("R7 peer mask write ignored", v, 32'h0FFF0FFE);
    wr(0, 10'h018, 32'h0001_0000);
    rd(1, 10'h01C, v); chk("R7 peer cmd write ignored", v, 0);
    wr(0, 10'h010, 32'h0);
    rd(1, 10'h010, v); chk("R7 peer ctrl write ignored", v, 32'h1);
  endtask

  task automatic t_unimpl_and_reverse();
    logic [31:0] v;
    wr(0, 10'h008, 32'h8000_0000);
    rd(0, 10'h00C, v); chk("R9 ch15 ignored", v, 32'h8);
    wr(1, 10'h018, 32'h0800_0000);
    rd(0, 10'h01C, v); chk("R2 status1 ch11", v, 32'h800);
    wr(0, 10'h004, 32'hFFFB_F7FF);
    wr(0, 10'h000, 32'h0001_0001);
    chk("R5 rx0 ch11", irq_rx0, 1);
    wr(0, 10'h018, 32'h0);
    wr(0, 10'h008, 32'h0000_0800);
    chk("R3 rx0 after ack", irq_rx0, 0);
  endtask

  initial begin
    #500us;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cfg();
    t_set();
    t_rx_irq();
    t_ack();
    t_tx_irq();
    t_priority();
    t_peer_write();
    t_unimpl_and_reverse();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule